// File: doc/BRIEF.md
# Oversampling Bit Recovery Stage

This block is the front end of a serial receiver whose line is not synchronous to the local clock. The line runs at one eighth of the local clock rate. Each line level is captured through a two-register synchronizer and pushed into a short history. A five-way majority vote over the history and the newest sample gives a filtered level, `voted`. Glitches of one or two samples are removed this way. The vote adds a fixed delay of a few cycles.

A free-running phase counter runs from 1 to 8, one lap per bit period, and marks one sampling point per lap. When `voted` falls from 1 to 0 while `realign_en` is high, the counter is pulled back to phase 2. This centres the sampling point three phases later, in the middle of the bit. Any sampling point due in that same cycle is dropped. At each sampling point, `strobe` rises for one cycle and `bit_out` shows the filtered level.

The surrounding frame logic decides when realignment is allowed. It also assembles the recovered bits into bytes.

Top module: `oversample_bit_recover`

## Requirements
- R1: While reset is held, and directly after it is released, `voted` = 1, `bit_out` = 1, `strobe` = 0 and `realign` = 0. The first `strobe` is visible after the 5th rising edge following the release of reset.
- R2: Take the edge that first captures a new line level as edge 1. When that level is held for at least 7 samples, `voted` still shows the old level after edge 4 and shows the new level after edge 5.
- R3: A line pulse that lasts only one or two samples never changes `voted` and never raises `realign`.
- R4: With no realignment, `strobe` is high for exactly one cycle in every 8 cycles.
- R5: `realign` is high for exactly the one cycle in which `voted` has just gone from 1 to 0 while `realign_en` is 1. That is the cycle after edge 5 in the numbering of R2. The next `strobe` follows 5 rising edges after the realign cycle.
- R6: A rising edge of `voted`, or a falling edge while `realign_en` is 0, leaves `realign` at 0 and leaves the 8-cycle `strobe` cadence unchanged.
- R7: If a realign cycle falls where a `strobe` was due on the next edge, that `strobe` is withheld.
- R8: `bit_out` is a register. In a `strobe` cycle, it equals the `voted` value of the previous cycle. Between strobes it holds its value.
- R9: With `realign_en` held high, a frame can be sent with 8 samples per bit. It is an idle-high line, then a 0 start bit, then 8 data bits MSB first. The strobed `bit_out` values that follow the start bit reproduce the data byte. The same holds at 7 or 9 samples per bit when a falling edge occurs at least every second bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, eight cycles per line bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous serial line, idle high |
| realign_en | input | 1 | Allows falling edges of the filtered level to realign the phase counter |
| voted | output | 1 | Majority-filtered line level |
| realign | output | 1 | One-cycle pulse when the phase counter is realigned |
| strobe | output | 1 | One-cycle sampling-point marker |
| bit_out | output | 1 | Filtered level captured at the sampling point |

## Verification
Most internal faults in this block appear at the ports within one bit period:
- A wrong synchronizer depth or vote threshold moves the cycle in which `voted` changes after a line step. Short pulses can also start to leak through.
- A wrong reload phase or strobe phase moves `strobe` away from exactly five edges after `realign`.
- A broken wrap moves the strobe cadence off 8 cycles on the very next lap.

The frame tests use 7, 8 and 9 samples per bit. With the wrong phase, a sampling point ends up on a bit boundary. The recovered byte then shows the fault as a flipped or missing bit.

// File: rtl/oversample_bit_recover.sv
module oversample_bit_recover #(
  parameter int SPB       = 8,
  parameter int HIST      = 4,
  parameter int RELOAD    = 2,
  parameter int STROBE_AT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic realign_en,
  output logic voted,
  output logic realign,
  output logic strobe,
  output logic bit_out
);

  localparam int CW    = $clog2(SPB + 1);
  localparam int VOTES = HIST + 1;
  localparam int NEED  = VOTES / 2 + 1;

  logic [1:0]       sync_q;
  logic [HIST-1:0]  hist_q;
  logic [VOTES-1:0] window;
  logic             v_q, v_d1;
  logic [CW-1:0]    cnt_q;
  logic             strobe_q, bit_q;
  logic             fire;

  function automatic logic majority(input logic [VOTES-1:0] w);
    int ones;
    ones = 0;
    for (int i = 0; i < VOTES; i++) ones += int'(w[i]);
    return ones >= NEED;
  endfunction

  assign window  = {hist_q, sync_q[1]};
  assign realign = v_d1 & ~v_q & realign_en;
  assign fire    = (cnt_q == CW'(STROBE_AT)) & ~realign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      hist_q   <= '1;
      v_q      <= 1'b1;
      v_d1     <= 1'b1;
      cnt_q    <= CW'(1);
      strobe_q <= 1'b0;
      bit_q    <= 1'b1;
    end else begin
      sync_q   <= {sync_q[0], line_in};
      hist_q   <= {hist_q[HIST-2:0], sync_q[1]};
      v_q      <= majority(window);
      v_d1     <= v_q;
      if (realign)                  cnt_q <= CW'(RELOAD);
      else if (cnt_q == CW'(SPB))   cnt_q <= CW'(1);
      else                          cnt_q <= cnt_q + CW'(1);
      strobe_q <= fire;
      if (fire) bit_q <= v_q;
    end
  end

  assign voted   = v_q;
  assign strobe  = strobe_q;
  assign bit_out = bit_q;

  assert_quiet_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&window) |=> voted);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CW'(1)) && (cnt_q <= CW'(SPB)));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (cnt_q == CW'(RELOAD)));

  assert_realign_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> $fell(voted));

  assert_no_strobe_after_realign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !strobe);

  assert_bit_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (bit_out == $past(voted)));

  assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> $stable(bit_out));

endmodule

// File: tb/tb_oversample_bit_recover.sv
module tb_oversample_bit_recover;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic realign_en = 1'b0;
  logic voted, realign, strobe, bit_out;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oversample_bit_recover dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .realign_en(realign_en),
    .voted(voted), .realign(realign), .strobe(strobe), .bit_out(bit_out)
  );

  // {data byte, samples per bit, extra idle samples}
  localparam logic [15:0] VECS [7] = '{
    16'hA583, 16'h0085, 16'hFF80, 16'h3C87, 16'h5592, 16'hAA74, 16'hAA96
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_strobe(output int p);
    do @(negedge clk); while (!strobe);
    p = cyc;
  endtask

  logic       mon_arm = 1'b0;
  logic       mon_started = 1'b0;
  int         mon_n = 0;
  logic [7:0] mon_rec = '0;
  logic       prev_v = 1'b1;
  int         r8_err = 0;

  always @(negedge clk) begin
    if (rst_n && strobe && bit_out !== prev_v) r8_err++;
    if (mon_arm && strobe) begin
      if (!mon_started) begin
        if (!bit_out) mon_started = 1'b1;
      end else if (mon_n < 8) begin
        mon_rec = {mon_rec[6:0], bit_out};
        mon_n++;
      end
    end
    prev_v = voted;
  end

  task automatic send_row(input logic [7:0] b, input int spb, input int idle);
    line_in = 1'b1;
    step(24 + idle);
    mon_started = 1'b0; mon_n = 0; mon_rec = '0; mon_arm = 1'b1;
    line_in = 1'b0;
    step(spb);
    for (int k = 7; k >= 0; k--) begin
      line_in = b[k];
      step(spb);
    end
    line_in = 1'b1;
    step(24);
    mon_arm = 1'b0;
  endtask

  initial begin
    int r, p, c;
    bit seen;
    step(3);
    check("R1 reset voted", voted, 1);
    check("R1 reset strobe", strobe, 0);
    rst_n = 1'b1;
    r = cyc;
    check("R1 release bit_out", bit_out, 1);
    check("R1 release realign", realign, 0);
    step(4);
    check("R1 no strobe after edge 4", strobe, 0);
    step(1);
    check("R1 first strobe after edge 5", strobe, 1);
    check("R1 edge count", cyc - r, 5);

    // R4: cadence with no realignment
    wait_strobe(p);
    step(7);
    check("R4 quiet before next strobe", strobe, 0);
    step(1);
    check("R4 strobe period 8", strobe, 1);

    // R9: frames from the vector table
    realign_en = 1'b1;
    foreach (VECS[i]) begin
      send_row(VECS[i][15:8], int'(VECS[i][7:4]), int'(VECS[i][3:0]));
      check($sformatf("R9 row %0d bit count", i), mon_n, 8);
      check($sformatf("R9 row %0d byte", i), mon_rec, VECS[i][15:8]);
    end

    // R3: short pulses
    line_in = 1'b1; step(16);
    seen = 0;
    line_in = 1'b0; step(1); line_in = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); if (!voted || realign) seen = 1; end
    check("R3 one-sample pulse filtered", seen, 0);
    seen = 0;
    line_in = 1'b0; step(2); line_in = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); if (!voted || realign) seen = 1; end
    check("R3 two-sample pulse filtered", seen, 0);

    // R6: falling edge with enable low
    realign_en = 1'b0;
    wait_strobe(p);
    step(2);
    line_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin step(1); if (realign) seen = 1; end
    check("R6 no realign while disabled", seen, 0);
    check("R6 disabled strobe keeps cadence", strobe, 1);
    step(8);
    check("R6 disabled cadence next lap", strobe, 1);

    // R6: rising edge with enable high
    step(8);
    realign_en = 1'b1;
    wait_strobe(p);
    step(2);
    line_in = 1'b1;
    seen = 0;
    for (int i = 0; i < 6; i++) begin step(1); if (realign) seen = 1; end
    check("R6 rising edge no realign", seen, 0);
    check("R6 rising edge cadence", strobe, 1);

    // R2, R5, R7: falling edge that lands on a due strobe
    step(16);
    wait_strobe(p);
    step(2);
    c = cyc;
    line_in = 1'b0;
    step(4);
    check("R2 voted holds old level after edge 4", voted, 1);
    check("R5 no early realign", realign, 0);
    step(1);
    check("R2 voted new level after edge 5", voted, 0);
    check("R5 realign with falling edge", realign, 1);
    check("R5 realign timing", cyc - c, 5);
    step(1);
    check("R5 realign one cycle", realign, 0);
    check("R7 due strobe withheld", strobe, 0);
    step(3);
    check("R5 no strobe before reload lap", strobe, 0);
    step(1);
    check("R5 strobe five edges after realign", strobe, 1);
    check("R8 bit_out captures low level", bit_out, 0);
    check("R5 strobe edge count", cyc - p, 12);
    step(1);
    check("R8 bit_out held", bit_out, 0);
    line_in = 1'b1;
    step(20);

    check("R8 bit_out equals prior voted at every strobe", r8_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule